// File: doc/BRIEF.md
# Dual-Byte Bidirectional Bus Transceiver

This block carries a 16-bit word between two ports, called A and B, in both directions at once. The word is split into two 8-bit bytes. Each byte has its own A-to-B path and its own B-to-A path. Every path holds one storage cell that works in one of three ways:
- passes its input straight through while its pass control is high;
- holds the last passed value once that control drops;
- takes a new value on each rising edge of a shared bus-clock input while the control stays low.

The bytes have separate pass controls and separate active-low drive enables for each direction. One bus-clock input serves both bytes and both directions. A single global disable input removes drive from every output at once.

The design is fully synchronous to the core clock `clk`. The bus clock `bus_clk` is sampled on `clk`, and a low-to-high change between two samples counts as one bus-clock edge. Data outputs always show the value of their path. Separate per-byte enable outputs tell the pad ring when to drive them.

Top module: `dual_byte_xcvr`

## Requirements
- R1: While a path's pass control is high, that path's output byte equals its input byte in the same cycle.
- R2: When a path's pass control goes from high to low, the output holds the input value from the last cycle in which the control was high.
- R3: While a path's pass control is low, a rising `bus_clk` (sampled low, then high) loads the input byte present in that cycle. The new value shows on the output after that `clk` edge. A falling `bus_clk` loads nothing.
- R4: While a path's pass control is low and no rising `bus_clk` is seen, the output keeps its stored value, whatever its input does.
- R5: Drive enables are active low per byte. `oe_ab_n[i]`=1 clears `b_oe[i]`, and `oe_ba_n[i]`=1 clears `a_oe[i]`. Byte i occupies bits [8i+7:8i].
- R6: `all_off`=1 clears every bit of `a_oe` and `b_oe`, whatever the per-byte enables say.
- R7: Each byte's pass controls and enables act only on that byte. Both bytes and both directions share the one `bus_clk`.
- R8: The B-to-A path (`b_in` to `a_out`, under `pass_ba` and `oe_ba_n`) behaves exactly like the A-to-B path.
- R9: With `all_off`=0, both enables of a byte may be low together. Both `a_oe[i]` and `b_oe[i]` are then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, bus-clock edge detector only |
| bus_clk | input | 1 | Shared load clock, sampled on clk |
| a_in | input | 16 | Data arriving at port A |
| b_in | input | 16 | Data arriving at port B |
| pass_ab | input | 2 | Per-byte pass control, A to B |
| pass_ba | input | 2 | Per-byte pass control, B to A |
| oe_ab_n | input | 2 | Per-byte active-low drive enable for port B |
| oe_ba_n | input | 2 | Per-byte active-low drive enable for port A |
| all_off | input | 1 | Global disable of all drive |
| a_out | output | 16 | Data to drive on port A |
| a_oe | output | 2 | Per-byte drive enable for port A |
| b_out | output | 16 | Data to drive on port B |
| b_oe | output | 2 | Per-byte drive enable for port B |

## Verification
Two functions can meet in one cycle:
- a bus-clock rising edge arrives while one byte is in pass mode and the other is holding;
- the global disable is raised while both per-byte enables of a byte are active.

The bench provokes the first by raising `bus_clk` in the same cycle that byte 1 opens and byte 0 stays closed. The scoreboard expects byte 1 to follow its input and byte 0 to load. For the second, it expects every enable cleared at once, with the data outputs unchanged.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // How a storage cell treats its input in the current cycle
    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,  // control high: follow input, track it
        MODE_LOAD = 2'd1,  // control low, bus-clock edge: take input
        MODE_KEEP = 2'd2   // control low, no edge: hold
    } cell_mode_e;

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = sig & ~st_q.prev;
endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             pass,
    input  logic             tick,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] hold;
    } cell_st_t;

    cell_st_t   st_d, st_q;
    cell_mode_e mode;

    always_comb begin
        if (pass)      mode = MODE_PASS;
        else if (tick) mode = MODE_LOAD;
        else           mode = MODE_KEEP;

        st_d = st_q;
        unique case (mode)
            MODE_PASS, MODE_LOAD: st_d.hold = din;
            default:              st_d.hold = st_q.hold;
        endcase
    end

    // Storage has no reset: contents are unknown until first loaded
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = (mode == MODE_PASS) ? din : st_q.hold;
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int BYTES = 2
) (
    input  logic             all_off,
    input  logic [BYTES-1:0] oe_n,
    output logic [BYTES-1:0] en
);
    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            en[i] = ~oe_n[i] & ~all_off;
        end
    end
endmodule

// File: rtl/dual_byte_xcvr.sv
module dual_byte_xcvr #(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int BUS_W = BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_clk,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    input  logic [BYTES-1:0] pass_ab,
    input  logic [BYTES-1:0] pass_ba,
    input  logic [BYTES-1:0] oe_ab_n,
    input  logic [BYTES-1:0] oe_ba_n,
    input  logic             all_off,
    output logic [BUS_W-1:0] a_out,
    output logic [BYTES-1:0] a_oe,
    output logic [BUS_W-1:0] b_out,
    output logic [BYTES-1:0] b_oe
);
    logic tick;

    xcvr_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (bus_clk),
        .rise (tick)
    );

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        xcvr_cell #(.WIDTH(BYTE_W)) u_ab (
            .clk (clk),
            .pass(pass_ab[g]),
            .tick(tick),
            .din (a_in[g*BYTE_W +: BYTE_W]),
            .dout(b_out[g*BYTE_W +: BYTE_W])
        );
        xcvr_cell #(.WIDTH(BYTE_W)) u_ba (
            .clk (clk),
            .pass(pass_ba[g]),
            .tick(tick),
            .din (b_in[g*BYTE_W +: BYTE_W]),
            .dout(a_out[g*BYTE_W +: BYTE_W])
        );
    end

    xcvr_drive #(.BYTES(BYTES)) u_drv_b (
        .all_off(all_off),
        .oe_n   (oe_ab_n),
        .en     (b_oe)
    );

    xcvr_drive #(.BYTES(BYTES)) u_drv_a (
        .all_off(all_off),
        .oe_n   (oe_ba_n),
        .en     (a_oe)
    );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int BUS_W = BYTES * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_clk,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] b_in,
    input logic [BYTES-1:0] pass_ab,
    input logic [BYTES-1:0] pass_ba,
    input logic [BYTES-1:0] oe_ab_n,
    input logic [BYTES-1:0] oe_ba_n,
    input logic             all_off,
    input logic [BUS_W-1:0] a_out,
    input logic [BYTES-1:0] a_oe,
    input logic [BUS_W-1:0] b_out,
    input logic [BYTES-1:0] b_oe
);
    AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> (a_oe == '0 && b_oe == '0)); // R6

    for (genvar g = 0; g < BYTES; g++) begin : g_chk
        AST_PASS_AB: assert property (@(posedge clk) disable iff (!rst_n)
            pass_ab[g] |-> b_out[g*BYTE_W +: BYTE_W] == a_in[g*BYTE_W +: BYTE_W]); // R1
        AST_PASS_BA: assert property (@(posedge clk) disable iff (!rst_n)
            pass_ba[g] |-> a_out[g*BYTE_W +: BYTE_W] == b_in[g*BYTE_W +: BYTE_W]); // R8
        AST_LOAD_AB: assert property (@(posedge clk) disable iff (!rst_n)
            (!pass_ab[g] && bus_clk && !$past(bus_clk)) |=>
            (pass_ab[g] || b_out[g*BYTE_W +: BYTE_W] == $past(a_in[g*BYTE_W +: BYTE_W]))); // R3
        AST_KEEP_AB: assert property (@(posedge clk) disable iff (!rst_n)
            (!pass_ab[g] && !(bus_clk && !$past(bus_clk))) |=>
            (pass_ab[g] || $stable(b_out[g*BYTE_W +: BYTE_W]))); // R4
        AST_OE_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            oe_ab_n[g] |-> !b_oe[g]); // R5
        AST_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (!all_off && !oe_ab_n[g] && !oe_ba_n[g]) |-> (a_oe[g] && b_oe[g])); // R9
    end
endmodule

bind dual_byte_xcvr xcvr_chk #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_clk(bus_clk),
    .a_in   (a_in),
    .b_in   (b_in),
    .pass_ab(pass_ab),
    .pass_ba(pass_ba),
    .oe_ab_n(oe_ab_n),
    .oe_ba_n(oe_ba_n),
    .all_off(all_off),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/test_dual_byte_xcvr.sv
module test_dual_byte_xcvr;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic [1:0]  aen;
        logic [1:0]  ben;
        bit          chk_data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_clk = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  pass_ab = '0, pass_ba = '0, oe_ab_n = 2'b11, oe_ba_n = 2'b11;
    logic        all_off = 1'b1;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];
    logic [15:0] h_ab = '0, h_ba = '0;
    logic        prev_x = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_byte_xcvr i_dual_byte_xcvr (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk),
        .a_in(a_in), .b_in(b_in),
        .pass_ab(pass_ab), .pass_ba(pass_ba),
        .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .all_off(all_off),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic step(input logic [15:0] ain, input logic [15:0] bin,
                        input logic [1:0] lab, input logic [1:0] lba,
                        input logic [1:0] oab, input logic [1:0] oba,
                        input logic off, input logic xc, input bit chkd,
                        input string tag);
        exp_t e;
        logic rise;
        @(negedge clk);
        a_in = ain; b_in = bin; pass_ab = lab; pass_ba = lba;
        oe_ab_n = oab; oe_ba_n = oba; all_off = off; bus_clk = xc;
        rise = xc & ~prev_x;
        prev_x = xc;
        for (int i = 0; i < 2; i++) begin
            if (lab[i] || rise) h_ab[i*8 +: 8] = ain[i*8 +: 8];
            if (lba[i] || rise) h_ba[i*8 +: 8] = bin[i*8 +: 8];
            e.b[i*8 +: 8] = lab[i] ? ain[i*8 +: 8] : h_ab[i*8 +: 8];
            e.a[i*8 +: 8] = lba[i] ? bin[i*8 +: 8] : h_ba[i*8 +: 8];
        end
        e.ben = ~oab & {2{~off}};
        e.aen = ~oba & {2{~off}};
        e.chk_data = chkd;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares each expected item after the clock edge it belongs to
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (a_oe !== e.aen || b_oe !== e.ben) begin
                n_err++;
                $display("FAIL %s enables: a_oe=%b b_oe=%b expected %b %b",
                         e.tag, a_oe, b_oe, e.aen, e.ben);
            end
            if (e.chk_data) begin
                n_chk++;
                if (a_out !== e.a || b_out !== e.b) begin
                    n_err++;
                    $display("FAIL %s data: a_out=%h b_out=%h expected %h %h",
                             e.tag, a_out, b_out, e.a, e.b);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state: everything disabled
        step(16'h0000, 16'h0000, 2'b00, 2'b00, 2'b11, 2'b11, 1'b1, 1'b0, 0, "R6 reset");
        // R1 / R8 pass-through loads every cell
        step(16'h1234, 16'habcd, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1, "R1 pass");
        step(16'h5678, 16'habcd, 2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1, "R1 follow");
        // R2 control falls: last passed value held
        step(16'hffff, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1, "R2 capture");
        // R4 input changes without an edge
        step(16'h0f0f, 16'hf0f0, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1, "R4 keep");
        // R3 rising bus clock loads
        step(16'h9a9a, 16'h3c3c, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1, "R3 load");
        step(16'h1111, 16'h2222, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1, "R4 high no edge");
        step(16'h3333, 16'h4444, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1, "R3 falling no load");
        // R7 byte independence, R5 per-byte enable
        step(16'h4455, 16'h4444, 2'b01, 2'b00, 2'b10, 2'b00, 1'b0, 1'b0, 1, "R7 R5 byte0 pass");
        // R7 shared clock: byte1 passes, byte0 loads on the same edge
        step(16'h7788, 16'h5566, 2'b10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1, "R7 shared edge");
        // R8 mirrored path with byte-wise enable
        step(16'h7788, 16'hdead, 2'b00, 2'b10, 2'b00, 2'b01, 1'b0, 1'b0, 1, "R8 ba path");
        step(16'h7788, 16'hbeef, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 1, "R8 ba hold");
        // R6 global disable overrides active enables
        step(16'h7788, 16'hbeef, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 1, "R6 all off");
        // R9 both directions driven together
        step(16'h7788, 16'hbeef, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1, "R9 both on");
        // R5 all per-byte enables high
        step(16'h7788, 16'hbeef, 2'b00, 2'b00, 2'b11, 2'b11, 1'b0, 1'b0, 1, "R5 all high");
        repeat (3) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule